// File: doc/BRIEF.md
# Windowed Multi-Sequence Sample Accumulator

This block coherently averages repeated acquisitions. A start pulse arms it and latches two values: how many samples make up one sequence and how many sequences are coming. Each sequence arrives as valid-qualified unsigned samples. Inside a sequence, every run of `WIN_LEN` adjacent samples is reduced to one window sum. Window sums from the same position in every sequence are added into a single stored total.

The totals live in on-chip memory. The first sequence writes its window sums directly. Each later sequence reads the stored total, adds its own window sum and writes the result back, so the memory never needs a clearing pass. After the last window of the last sequence has been stored, `ready_o` rises. A consumer then pulls the totals out in ascending word order, one batch of `BATCH_BYTES*8/SUM_W` words per request pulse. A `finish_i` pulse ends the readout and returns the block to idle, where it waits for the next start.

Top module: `win_accum`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ready_o` and `word_valid_o` are both 0.
- R2: Word k equals the sum, taken over every sequence, of samples 4k to 4k+3 of that sequence, wrapped to 32 bits. With one sequence of 1..8 followed by one of 11..18, the words are 60 and 92.
- R3: A new run after `finish_i` returns only that run's totals. No value from an earlier run carries over.
- R4: Only cycles with `smp_valid_i` high advance the window. Idle cycles inside a sequence or between sequences do not change which samples are grouped together.
- R5: `ready_o` rises exactly two cycles after the clock edge that takes the final sample of the final sequence. It stays high until `finish_i`.
- R6: A batch request sampled at edge e, while ready and with no batch in flight, produces `word_valid_o` pulses after edges e+1 through e+BATCH. These carry consecutive words that continue from where the previous batch stopped.
- R7: A batch request is ignored while a batch is still streaming, and also before `ready_o` is high.
- R8: Samples presented while idle, or after `ready_o` has risen, are ignored.
- R9: `finish_i` while ready clears `ready_o` on the next edge. The block then accepts a new `start_i`.
- R10: A batch that reaches the last stored word stops there. No words beyond `smp_count_i/4` are ever emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle arm pulse, honoured only while idle |
| smp_count_i | input | CNT_W (9) | Samples per sequence, latched on start |
| seq_count_i | input | SEQ_W (16) | Number of sequences, latched on start |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_data_i | input | SAMPLE_W (12) | Unsigned sample |
| ready_o | output | 1 | Totals complete, readout may begin |
| batch_req_i | input | 1 | One-cycle request for the next batch |
| word_valid_o | output | 1 | `word_o` carries a stored total |
| word_o | output | SUM_W (32) | Stored total being read out |
| finish_i | input | 1 | Ends the readout and returns the block to idle |

## Verification
The assertions assume three things about the inputs:
- `smp_count_i` is a non-zero multiple of the window length no larger than `MAX_SAMPLES`.
- `seq_count_i` is non-zero.
- Windows are at least two samples long, so window emissions are never back to back and the read-add-write step never overlaps itself.

The stimulus keeps within these limits. It uses sample counts of 8, 12, 16 and 256 with the default window of four. It also inserts idle cycles inside and between sequences, stray samples while idle and while ready, early and overlapping batch requests, and a final partial batch.

// File: rtl/win_accum_pkg.sv
package win_accum_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_FLUSH, ST_READY} acc_state_e;
endpackage

// File: rtl/win_accum_ram.sv
module win_accum_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/win_accum_window.sv
module win_accum_window #(
  parameter int SAMPLE_W = 12,
  parameter int SUM_W    = 32,
  parameter int WIN_LEN  = 4,
  parameter int AW       = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic [AW-1:0]       last_idx_i,
  output logic [SUM_W-1:0]    sum_o,
  output logic [AW-1:0]       addr_o,
  output logic                v_o,
  output logic                last_o
);
  localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

  logic [PW-1:0]    pos_q;
  logic [SUM_W-1:0] acc_q;
  logic [AW-1:0]    idx_q;
  logic [SUM_W-1:0] acc_next;

  assign acc_next = acc_q + SUM_W'(data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      acc_q  <= '0;
      idx_q  <= '0;
      sum_o  <= '0;
      addr_o <= '0;
      v_o    <= 1'b0;
      last_o <= 1'b0;
    end else begin
      v_o <= 1'b0;
      if (clear_i) begin
        pos_q <= '0;
        acc_q <= '0;
        idx_q <= '0;
      end else if (en_i && valid_i) begin
        if (pos_q == PW'(WIN_LEN - 1)) begin
          sum_o  <= acc_next;
          addr_o <= idx_q;
          v_o    <= 1'b1;
          last_o <= (idx_q == last_idx_i);
          acc_q  <= '0;
          pos_q  <= '0;
          idx_q  <= (idx_q == last_idx_i) ? '0 : idx_q + 1'b1;
        end else begin
          acc_q <= acc_next;
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  // R4: emissions are at least one window apart, so read-add-write never overlaps
  win_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |=> !v_o);
endmodule

// File: rtl/win_accum.sv
module win_accum #(
  parameter int SAMPLE_W    = 12,
  parameter int SUM_W       = 32,
  parameter int MAX_SAMPLES = 256,
  parameter int WIN_LEN     = 4,
  parameter int BATCH_BYTES = 8,
  parameter int SEQ_W       = 16,
  parameter int CNT_W       = $clog2(MAX_SAMPLES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    smp_count_i,
  input  logic [SEQ_W-1:0]    seq_count_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                ready_o,
  input  logic                batch_req_i,
  output logic                word_valid_o,
  output logic [SUM_W-1:0]    word_o,
  input  logic                finish_i
);
  import win_accum_pkg::*;

  localparam int WORDS = MAX_SAMPLES / WIN_LEN;
  localparam int AW    = $clog2(WORDS);
  localparam int BATCH = (BATCH_BYTES * 8) / SUM_W;
  localparam int BW    = $clog2(BATCH + 1);

  acc_state_e       state_q;
  logic [AW:0]      words_q;
  logic [SEQ_W-1:0] seq_total_q, seq_idx_q;
  logic [AW:0]      rd_ptr_q;
  logic [BW-1:0]    burst_q;
  logic             rvalid_q;

  logic             win_v, win_last;
  logic [SUM_W-1:0] win_sum;
  logic [AW-1:0]    win_addr, last_idx;

  logic             p_v, p_first;
  logic [AW-1:0]    p_addr;
  logic [SUM_W-1:0] p_sum;

  logic             mem_we;
  logic [SUM_W-1:0] mem_wdata, mem_rdata;
  logic [AW-1:0]    mem_raddr;
  logic             rd_en;
  logic [CNT_W-1:0] words_full;

  assign words_full = smp_count_i / CNT_W'(WIN_LEN);
  assign last_idx   = AW'(words_q - 1'b1);
  assign rd_en      = (state_q == ST_READY) && (burst_q != '0) && (rd_ptr_q < words_q);

  win_accum_window #(
    .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .WIN_LEN(WIN_LEN), .AW(AW)
  ) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_i && (state_q == ST_IDLE)),
    .en_i       (state_q == ST_ACC),
    .valid_i    (smp_valid_i),
    .data_i     (smp_data_i),
    .last_idx_i (last_idx),
    .sum_o      (win_sum),
    .addr_o     (win_addr),
    .v_o        (win_v),
    .last_o     (win_last)
  );

  // read issued with the emission, add and write one cycle later
  assign mem_raddr = (state_q == ST_READY) ? rd_ptr_q[AW-1:0] : win_addr;
  assign mem_we    = p_v;
  assign mem_wdata = p_first ? p_sum : p_sum + mem_rdata;

  win_accum_ram #(.W(SUM_W), .DEPTH(WORDS), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (p_addr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_v     <= 1'b0;
      p_first <= 1'b0;
      p_addr  <= '0;
      p_sum   <= '0;
    end else begin
      p_v     <= win_v;
      p_first <= (seq_idx_q == '0);
      p_addr  <= win_addr;
      p_sum   <= win_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      words_q     <= '0;
      seq_total_q <= '0;
      seq_idx_q   <= '0;
      rd_ptr_q    <= '0;
      burst_q     <= '0;
      rvalid_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q     <= ST_ACC;
          words_q     <= words_full[AW:0];
          seq_total_q <= seq_count_i;
          seq_idx_q   <= '0;
          rd_ptr_q    <= '0;
          burst_q     <= '0;
        end
        ST_ACC: if (win_v && win_last) begin
          seq_idx_q <= seq_idx_q + 1'b1;
          if (seq_idx_q == seq_total_q - 1'b1) state_q <= ST_FLUSH;
        end
        ST_FLUSH: state_q <= ST_READY;
        ST_READY: begin
          if (finish_i) begin
            state_q <= ST_IDLE;
            burst_q <= '0;
          end else if (rd_en) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
            burst_q  <= burst_q - 1'b1;
          end else if (burst_q != '0) begin
            burst_q <= '0;
          end else if (batch_req_i) begin
            burst_q <= BW'(BATCH);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o      = (state_q == ST_READY);
  assign word_valid_o = rvalid_q;
  assign word_o       = mem_rdata;

  // R5
  ready_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(mem_we));
  // R8
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (state_q == ST_ACC || state_q == ST_FLUSH));
  // R6
  word_in_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(state_q == ST_READY));
  // R2
  win_addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_v |-> ({1'b0, win_addr} < words_q));
endmodule

// File: tb/win_accum_tb.sv
module win_accum_tb;
  localparam int SAMPLE_W = 12;
  localparam int SUM_W    = 32;
  localparam int MAXS     = 256;
  localparam int WIN      = 4;
  localparam int BATCH    = 2;
  localparam int CNT_W    = $clog2(MAXS + 1);

  logic                clk_i = 1'b0;
  logic                rst_ni;
  logic                start_i, smp_valid_i, batch_req_i, finish_i;
  logic [CNT_W-1:0]    smp_count_i;
  logic [15:0]         seq_count_i;
  logic [SAMPLE_W-1:0] smp_data_i;
  logic                ready_o, word_valid_o;
  logic [SUM_W-1:0]    word_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] exp_words [MAXS/WIN];
  int words, rd_pos;

  always #5 clk_i = ~clk_i;

  win_accum u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .smp_count_i(smp_count_i),
    .seq_count_i(seq_count_i), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .ready_o(ready_o), .batch_req_i(batch_req_i), .word_valid_o(word_valid_o),
    .word_o(word_o), .finish_i(finish_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every word the design emits (R2, R6, R10)
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && word_valid_o === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected word", word_o, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(word_o === e, "R2 word value", word_o, e);
      end
    end
  end

  task automatic run_acc(input int smp, input int seqs, input bit rnd, input bit gaps, input bit early_req);
    words  = smp / WIN;
    rd_pos = 0;
    for (int k = 0; k < words; k++) exp_words[k] = '0;
    // R8: stray samples while idle
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); smp_valid_i = 1'b1; smp_data_i = 12'hfff;
    end
    @(negedge clk_i);
    smp_valid_i = 1'b0; smp_count_i = CNT_W'(smp); seq_count_i = 16'(seqs); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    for (int s = 0; s < seqs; s++) begin
      for (int i = 0; i < smp; i++) begin
        logic [SAMPLE_W-1:0] v;
        v = rnd ? SAMPLE_W'($urandom_range(0, 4095)) : SAMPLE_W'(s * 10 + i + 1);
        exp_words[i / WIN] += 32'(v);
        @(negedge clk_i);
        smp_valid_i = 1'b1; smp_data_i = v;
        batch_req_i = early_req && s == 0 && i == 2; // R7: request before ready
        if (gaps && i % 3 == 1) begin // R4: hole inside a sequence
          @(negedge clk_i); smp_valid_i = 1'b0; batch_req_i = 1'b0;
        end
      end
      @(negedge clk_i); smp_valid_i = 1'b0; batch_req_i = 1'b0;
      if (s == seqs - 1) chk(ready_o === 1'b0, "R5 ready early", 32'(ready_o), 0);
      else repeat (3) @(negedge clk_i);
    end
    repeat (2) @(negedge clk_i);
    chk(ready_o === 1'b1, "R5 ready rise", 32'(ready_o), 1);
    // R8: stray samples while ready
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); smp_valid_i = 1'b1; smp_data_i = 12'hfff;
    end
    @(negedge clk_i); smp_valid_i = 1'b0;
  endtask

  task automatic batch(input bit double_req);
    int n;
    n = (words - rd_pos < BATCH) ? words - rd_pos : BATCH;
    for (int k = 0; k < n; k++) exp_q.push_back(exp_words[rd_pos + k]);
    rd_pos += n;
    @(negedge clk_i); batch_req_i = 1'b1;
    @(negedge clk_i); batch_req_i = double_req; // R7: second request while streaming
    repeat (BATCH) @(negedge clk_i);
    batch_req_i = 1'b0;
    #1;
    chk(exp_q.size() == 0, "R6 batch length/latency", 32'(exp_q.size()), 0);
    chk(ready_o === 1'b1, "R5 ready held", 32'(ready_o), 1);
  endtask

  task automatic finish_run();
    @(negedge clk_i); finish_i = 1'b1;
    @(negedge clk_i); finish_i = 1'b0;
    #1;
    chk(ready_o === 1'b0, "R9 finish clears ready", 32'(ready_o), 0);
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R10 no trailing words", 32'(exp_q.size()), 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    rst_ni = 1'b0; start_i = 0; smp_valid_i = 0; batch_req_i = 0; finish_i = 0;
    smp_count_i = '0; seq_count_i = '0; smp_data_i = '0;
    repeat (3) @(negedge clk_i);
    chk(ready_o === 1'b0, "R1 reset ready", 32'(ready_o), 0);
    chk(word_valid_o === 1'b0, "R1 reset valid", 32'(word_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o === 1'b0 && word_valid_o === 1'b0, "R1 after reset", 32'({ready_o, word_valid_o}), 0);

    // R2: known pattern 1..8 and 11..18 -> 60, 92
    run_acc(8, 2, 1'b0, 1'b0, 1'b0);
    chk(exp_words[0] == 60 && exp_words[1] == 92, "R2 model", exp_words[0], 60);
    batch(1'b0);
    finish_run();

    // R3, R4, R7: random run after the first, gaps, early and overlapping requests
    run_acc(16, 3, 1'b1, 1'b1, 1'b1);
    batch(1'b1);
    batch(1'b0);
    finish_run();

    // R10: partial final batch and a request past the end
    run_acc(12, 1, 1'b1, 1'b0, 1'b0);
    batch(1'b0);
    batch(1'b0);
    batch(1'b0);
    finish_run();

    // full depth
    run_acc(MAXS, 2, 1'b1, 1'b0, 1'b0);
    for (int b = 0; b < MAXS / WIN / BATCH; b++) batch(b % 5 == 0);
    finish_run();

    report();
  end
endmodule